// File: doc/BRIEF.md
# Descriptor-Chaining DMA Control Engine

This block sequences one fly-by DMA channel that moves 32-bit words between system memory and a local FIFO. A host sees four 32-bit registers: current address, remaining word count, a command/status word and a next-descriptor pointer. A fifth write-only location clears the pending interrupt. The engine does not move data itself. It raises a burst request to a bus-tenure controller, which reports back each completed data phase, and the engine advances its address and count on every one of those phases. A burst has no fixed length: the request stays up for as long as words remain, the device still asks for service and the process is running.

There are two modes. In normal mode the host programs the address, the count and the command word, and the run ends when the count reaches zero. In chaining mode the host programs only the pointer. The engine then reads four-word descriptors through a single-word read port. Each descriptor holds, in this order, a control word, a count, a next pointer and a start address. The engine keeps following the pointers until it finishes a descriptor whose next pointer is zero. The control word in each descriptor replaces the cycle type and the interrupt policy for that descriptor.

Top module: `dma_chain_engine`

## Requirements
- R1: Register select 0 reads/writes the address, 1 the count, 2 the command word, 3 the next pointer. Select 4 is the clear-interrupt register, and any other select reads zero. All registers reset to zero. In the command word only bits 17:16, 14 and 12:9 hold what is written, bit 8 is the start bit, bits 0 and 1 are status bits, and every other bit reads zero.
- R2: Each completed data phase (`beat_done` while `xfer_req` is high) adds 4 to the address and subtracts 1 from the count.
- R3: Bit 0 (done) sets and bit 8 (start) clears in the cycle after the final descriptor's count is found to be zero. Done clears on reset, on a command write with bit 8 = 0, on a non-zero count write, and when a new process is launched.
- R4: Starting normal mode with a count of zero sets done without ever raising `xfer_req`.
- R5: `xfer_req` is high only while a process is transferring, the count is non-zero and `dev_req` is high. `xfer_dir` is 1 for cycle type 0111 in bits 12:9 (memory write, FIFO to memory) and 0 for 0110 (memory read, memory to FIFO).
- R6: A command write with bit 8 = 0 during a transfer keeps the request up only until `tenure_end`, if a data phase has completed in the current tenure. Address and count are then held. Writing bit 8 = 1 resumes from the held values.
- R7: Bit 14 = 1 at start selects chaining. A fetch reads the words at pointer+0, +4, +8 and +12 in that order. `fetch_req` and `fetch_addr` are held until `fetch_valid`, and no transfer request is raised during a fetch.
- R8: The words read at +0, +4, +8 and +12 load the command fields 17:16 and 12:9, the count, the next pointer and the address respectively. Transfers begin only after the +12 word is taken.
- R9: When a descriptor's count is exhausted, a non-zero next pointer starts a fetch at that pointer. A zero pointer ends the process.
- R10: Interrupt policy (bits 17:16): 01 interrupts at the end of every descriptor (or of a normal run), 10 only at the end of the final descriptor or of a normal run, and 00 or 11 never.
- R11: The interrupt is visible on `irq` and as command bit 1. It stays set until any write to select 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 3 | Host register select |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for `reg_sel` (combinational) |
| fetch_req | output | 1 | Descriptor word read request |
| fetch_addr | output | 32 | Descriptor word address |
| fetch_valid | input | 1 | Read response valid |
| fetch_data | input | 32 | Read response word |
| dev_req | input | 1 | Demand request from the FIFO side |
| xfer_req | output | 1 | Burst request to the bus-tenure controller |
| xfer_dir | output | 1 | 1 = FIFO to memory, 0 = memory to FIFO |
| xfer_addr | output | 32 | Memory address of the next data phase |
| beat_done | input | 1 | One data phase completed |
| tenure_end | input | 1 | Current bus transaction ended |
| irq | output | 1 | Interrupt pending |

## Verification
The assertions assume that `beat_done` counts only while a request is up, and that `fetch_valid` answers a pending read and is never raised on its own. The bench's bus and memory models hold to this. They drive one cycle after the falling edge, and only after sampling `xfer_req` or `fetch_req`. The property on count stepping also assumes that the host does not write the count during a data phase. The bench does host writes only while no data phase is being granted, and during the suspend test it first stops granting.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XFER  = 2'd2
  } eng_state_e;

  // command word field positions
  localparam int BIT_DONE  = 0;
  localparam int BIT_IRQ   = 1;
  localparam int BIT_START = 8;
  localparam int BIT_DIR   = 9;
  localparam int BIT_MODE  = 14;
  localparam int POL_LO    = 16;

  // bits that hold host-written fields (start kept separately)
  localparam logic [WORD_W-1:0] CMD_FIELD_MASK = 32'h0003_5E00;
  // bits a descriptor control word replaces
  localparam logic [WORD_W-1:0] CTRL_LOAD_MASK = 32'h0003_1E00;

  // descriptor word order
  localparam int IDX_CTRL = 0;
  localparam int IDX_CNT  = 1;
  localparam int IDX_NEXT = 2;
  localparam int IDX_SRC  = 3;

  function automatic logic [WORD_W-1:0] step_addr(input logic [WORD_W-1:0] a);
    return a + WORD_W'(4);
  endfunction

  function automatic logic [WORD_W-1:0] step_count(input logic [WORD_W-1:0] c);
    return c - WORD_W'(1);
  endfunction

  function automatic logic irq_fires(input logic [1:0] pol, input logic final_chain);
    return (pol == 2'b01) || ((pol == 2'b10) && final_chain);
  endfunction

endpackage

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
  import dma_chain_pkg::*;
#(
  parameter int DESC_WORDS = 4,
  localparam int IDX_W = $clog2(DESC_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [WORD_W-1:0] base,
  input  logic              rsp_valid,
  output logic              rd_req,
  output logic [WORD_W-1:0] rd_addr,
  output logic              word_take,
  output logic [IDX_W-1:0]  word_idx,
  output logic              word_last
);

  logic              active_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] base_q;

  assign rd_req    = active_q;
  assign rd_addr   = base_q + (WORD_W'(idx_q) << 2);
  assign word_take = active_q && rsp_valid;
  assign word_idx  = idx_q;
  assign word_last = (idx_q == IDX_W'(DESC_WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
    end else if (launch) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      base_q   <= base;
    end else if (word_take) begin
      idx_q <= idx_q + IDX_W'(1);
      if (word_last) active_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_irq_policy.sv
module dma_irq_policy
  import dma_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chain_end,
  input  logic       final_chain,
  input  logic [1:0] policy,
  input  logic       clr,
  output logic       fire,
  output logic       irq
);

  assign fire = chain_end && irq_fires(policy, final_chain);

  always_ff @(posedge clk) begin
    if (!rst_n)    irq <= 1'b0;
    else if (fire) irq <= 1'b1;
    else if (clr)  irq <= 1'b0;
  end

endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dma_chain_pkg::*;
#(
  parameter int REG_SEL_W  = 3,
  parameter int DESC_WORDS = 4,
  localparam int IDX_W = $clog2(DESC_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [REG_SEL_W-1:0] reg_sel,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  output logic                 fetch_req,
  output logic [WORD_W-1:0]    fetch_addr,
  input  logic                 fetch_valid,
  input  logic [WORD_W-1:0]    fetch_data,
  input  logic                 dev_req,
  output logic                 xfer_req,
  output logic                 xfer_dir,
  output logic [WORD_W-1:0]    xfer_addr,
  input  logic                 beat_done,
  input  logic                 tenure_end,
  output logic                 irq
);

  eng_state_e        state_q;
  logic [WORD_W-1:0] src_q, cnt_q, next_q, cmd_q;
  logic              start_q, done_q, in_tenure_q;

  // named internal events
  logic wr_src, wr_cnt, wr_cmd, wr_next, wr_clr;
  logic beat_ok, chain_end, final_chain, finish;
  logic launch_norm, launch_chain, fetch_launch;
  logic word_take, word_last, irq_fire;
  logic [IDX_W-1:0] word_idx;

  assign wr_src  = reg_we && (reg_sel == REG_SEL_W'(0));
  assign wr_cnt  = reg_we && (reg_sel == REG_SEL_W'(1));
  assign wr_cmd  = reg_we && (reg_sel == REG_SEL_W'(2));
  assign wr_next = reg_we && (reg_sel == REG_SEL_W'(3));
  assign wr_clr  = reg_we && (reg_sel == REG_SEL_W'(4));

  assign launch_norm  = wr_cmd && reg_wdata[BIT_START] && (state_q == ST_IDLE) && !reg_wdata[BIT_MODE];
  assign launch_chain = wr_cmd && reg_wdata[BIT_START] && (state_q == ST_IDLE) &&  reg_wdata[BIT_MODE];

  assign xfer_req    = (state_q == ST_XFER) && (cnt_q != '0) && dev_req && (start_q || in_tenure_q);
  assign xfer_dir    = cmd_q[BIT_DIR];
  assign xfer_addr   = src_q;
  assign beat_ok     = beat_done && xfer_req;
  assign chain_end   = (state_q == ST_XFER) && (cnt_q == '0);
  assign final_chain = !cmd_q[BIT_MODE] || (next_q == '0);
  assign finish      = chain_end && final_chain;
  assign fetch_launch = launch_chain || (chain_end && !final_chain);

  dma_desc_fetch #(.DESC_WORDS(DESC_WORDS)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (fetch_launch),
    .base      (next_q),
    .rsp_valid (fetch_valid),
    .rd_req    (fetch_req),
    .rd_addr   (fetch_addr),
    .word_take (word_take),
    .word_idx  (word_idx),
    .word_last (word_last)
  );

  dma_irq_policy u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .chain_end   (chain_end),
    .final_chain (final_chain),
    .policy      (cmd_q[POL_LO+1:POL_LO]),
    .clr         (wr_clr),
    .fire        (irq_fire),
    .irq         (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      src_q       <= '0;
      cnt_q       <= '0;
      next_q      <= '0;
      cmd_q       <= '0;
      start_q     <= 1'b0;
      done_q      <= 1'b0;
      in_tenure_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (launch_chain) state_q <= ST_FETCH;
                  else if (launch_norm) state_q <= ST_XFER;
        ST_FETCH: if (word_take && word_last) state_q <= ST_XFER;
        ST_XFER:  if (chain_end) state_q <= final_chain ? ST_IDLE : ST_FETCH;
        default:  state_q <= ST_IDLE;
      endcase

      if (wr_src) src_q <= reg_wdata;
      else if (beat_ok) src_q <= step_addr(src_q);
      else if (word_take && word_idx == IDX_W'(IDX_SRC)) src_q <= fetch_data;

      if (wr_cnt) cnt_q <= reg_wdata;
      else if (beat_ok) cnt_q <= step_count(cnt_q);
      else if (word_take && word_idx == IDX_W'(IDX_CNT)) cnt_q <= fetch_data;

      if (wr_next) next_q <= reg_wdata;
      else if (word_take && word_idx == IDX_W'(IDX_NEXT)) next_q <= fetch_data;

      if (wr_cmd) cmd_q <= reg_wdata & CMD_FIELD_MASK;
      else if (word_take && word_idx == IDX_W'(IDX_CTRL))
        cmd_q <= (cmd_q & ~CTRL_LOAD_MASK) | (fetch_data & CTRL_LOAD_MASK);

      if (wr_cmd) start_q <= reg_wdata[BIT_START];
      else if (finish) start_q <= 1'b0;

      if (finish) done_q <= 1'b1;
      else if ((wr_cmd && !reg_wdata[BIT_START]) || (wr_cnt && reg_wdata != '0) ||
               launch_norm || launch_chain) done_q <= 1'b0;

      if (state_q != ST_XFER) in_tenure_q <= 1'b0;
      else if (tenure_end) in_tenure_q <= 1'b0;
      else if (beat_ok) in_tenure_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (reg_sel)
      REG_SEL_W'(0): reg_rdata = src_q;
      REG_SEL_W'(1): reg_rdata = cnt_q;
      REG_SEL_W'(2): begin
        reg_rdata            = cmd_q;
        reg_rdata[BIT_START] = start_q;
        reg_rdata[BIT_IRQ]   = irq;
        reg_rdata[BIT_DONE]  = done_q;
      end
      REG_SEL_W'(3): reg_rdata = next_q;
      default:       reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dma_chain_checks.sv
module dma_chain_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        beat_ok,
  input logic        wr_src,
  input logic        wr_cnt,
  input logic [31:0] src_q,
  input logic [31:0] cnt_q,
  input logic        xfer_req,
  input logic        fetch_req,
  input logic        fetch_valid,
  input logic [31:0] fetch_addr,
  input logic        done_q,
  input logic        start_q,
  input logic        irq,
  input logic        chain_end
);

  // R2: address advances one word per data phase
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_ok && !wr_src |=> src_q == $past(src_q) + 32'd4);

  // R2: count drops by one per data phase
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_ok && !wr_cnt |=> cnt_q == $past(cnt_q) - 32'd1);

  // R7: no transfer request while a descriptor is being read
  p_fetch_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> !xfer_req);

  // R7: a pending read holds its address until answered
  p_fetch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !fetch_valid |=> fetch_req && $stable(fetch_addr));

  // R7: successive descriptor words are one word apart
  p_fetch_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && fetch_valid |=> !fetch_req || fetch_addr == $past(fetch_addr) + 32'd4);

  // R3: done never coexists with a running start bit
  p_done_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !start_q);

  // R10: an interrupt only rises after a descriptor or run ends
  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(chain_end));

endmodule

bind dma_chain_engine dma_chain_checks u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .beat_ok     (beat_ok),
  .wr_src      (wr_src),
  .wr_cnt      (wr_cnt),
  .src_q       (src_q),
  .cnt_q       (cnt_q),
  .xfer_req    (xfer_req),
  .fetch_req   (fetch_req),
  .fetch_valid (fetch_valid),
  .fetch_addr  (fetch_addr),
  .done_q      (done_q),
  .start_q     (start_q),
  .irq         (irq),
  .chain_end   (chain_end)
);

// File: tb/sim_dma_chain_engine.sv
module sim_dma_chain_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fetch_req;
  logic [31:0] fetch_addr;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_data = '0;
  logic        dev_req = 1'b0;
  logic        xfer_req;
  logic        xfer_dir;
  logic [31:0] xfer_addr;
  logic        beat_done = 1'b0;
  logic        tenure_end = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;

  // bus / memory model state
  logic        bus_en = 1'b0;
  logic        exp_dir = 1'b0;
  logic        mwait = 1'b0;
  int          beats = 0;
  int          req_seen = 0;
  int          dir_err = 0;
  int          nfetch = 0;
  logic [31:0] beat_log [0:63];
  logic [31:0] fetch_log [0:31];
  logic [31:0] ctrl1 = '0, ctrl2 = '0, ctrl3 = '0;

  always #5 clk = ~clk;

  dma_chain_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .dev_req(dev_req), .xfer_req(xfer_req), .xfer_dir(xfer_dir),
    .xfer_addr(xfer_addr), .beat_done(beat_done), .tenure_end(tenure_end), .irq(irq)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    case (a)
      32'h100: return ctrl1;
      32'h104: return 32'd2;
      32'h108: return 32'h200;
      32'h10C: return 32'h4000;
      32'h200: return ctrl2;
      32'h204: return 32'd0;
      32'h208: return 32'h300;
      32'h20C: return 32'h5000;
      32'h300: return ctrl3;
      32'h304: return 32'd3;
      32'h308: return 32'd0;
      32'h30C: return 32'h6000;
      default: return 32'hDEAD_0000;
    endcase
  endfunction

  // bus-tenure model: grants a data phase whenever a request is seen
  always @(negedge clk) begin
    #1;
    beat_done = 1'b0;
    if (xfer_req) req_seen++;
    if (xfer_req && bus_en) begin
      beat_done = 1'b1;
      if (beats < 64) beat_log[beats] = xfer_addr;
      if (xfer_dir !== exp_dir) dir_err++;
      beats++;
    end
  end

  // memory model: answers each read after one wait cycle
  always @(negedge clk) begin
    #1;
    if (fetch_valid) fetch_valid = 1'b0;
    else if (fetch_req) begin
      if (mwait) begin
        fetch_valid = 1'b1;
        fetch_data  = mem_word(fetch_addr);
        if (nfetch < 32) fetch_log[nfetch] = fetch_addr;
        nfetch++;
        mwait = 1'b0;
      end else mwait = 1'b1;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] v;
    logic hit = 1'b0;
    for (int k = 0; k < 2000 && !hit; k++) begin
      @(negedge clk);
      rd(3'd2, v);
      hit = v[0];
    end
    chk(hit, tag, {31'd0, hit}, 32'd1);
  endtask

  task automatic run_normal(input int n, input logic [3:0] ct, input logic [1:0] pol);
    logic [31:0] v;
    logic exp_irq;
    wr(3'd4, 32'd0);
    wr(3'd0, 32'h1000);
    wr(3'd1, n);
    beats = 0; dir_err = 0;
    exp_dir = (ct == 4'b0111);
    bus_en = 1'b1; dev_req = 1'b1;
    wr(3'd2, ({14'd0, pol, 16'd0}) | ({28'd0, ct} << 9) | 32'h100);
    wait_done("R3 normal run completes");
    chk(beats == n, "R2 beat count", beats, n);
    for (int k = 0; k < n; k++)
      chk(beat_log[k] == 32'h1000 + 4 * k, "R2 per-beat address", beat_log[k], 32'h1000 + 4 * k);
    rd(3'd0, v); chk(v == 32'h1000 + 4 * n, "R2 final address", v, 32'h1000 + 4 * n);
    rd(3'd1, v); chk(v == 0, "R2 final count", v, 0);
    chk(dir_err == 0, "R5 direction from cycle type", dir_err, 0);
    exp_irq = (pol == 2'b01) || (pol == 2'b10);
    chk(irq == exp_irq, "R10 normal-run policy", irq, exp_irq);
    rd(3'd2, v);
    chk(v == ({14'd0, pol, 16'd0} | ({28'd0, ct} << 9) | {30'd0, exp_irq, 1'b1}),
        "R3 start cleared, status bits", v,
        {14'd0, pol, 16'd0} | ({28'd0, ct} << 9) | {30'd0, exp_irq, 1'b1});
  endtask

  task automatic run_chain(input logic [31:0] c1, input logic [31:0] c2, input logic [31:0] c3,
                           input logic exp_irq, input string tag);
    logic [31:0] v;
    logic [31:0] bases [0:2];
    bases[0] = 32'h100; bases[1] = 32'h200; bases[2] = 32'h300;
    ctrl1 = c1; ctrl2 = c2; ctrl3 = c3;
    wr(3'd4, 32'd0);
    wr(3'd3, 32'h100);
    beats = 0; nfetch = 0; dir_err = 0;
    exp_dir = c3[9];
    bus_en = 1'b1; dev_req = 1'b1;
    wr(3'd2, 32'h4100);
    wait_done("R9 chain terminates at null pointer");
    chk(nfetch == 12, "R7 fetch word count", nfetch, 12);
    for (int d = 0; d < 3; d++)
      for (int w = 0; w < 4; w++)
        chk(fetch_log[d * 4 + w] == bases[d] + 4 * w, "R7 fetch order",
            fetch_log[d * 4 + w], bases[d] + 4 * w);
    chk(beats == 5, "R8 beats from descriptor counts", beats, 5);
    chk(beat_log[0] == 32'h4000 && beat_log[1] == 32'h4004, "R8 first start address",
        beat_log[1], 32'h4004);
    chk(beat_log[2] == 32'h6000 && beat_log[4] == 32'h6008, "R9 third descriptor addresses",
        beat_log[4], 32'h6008);
    rd(3'd0, v); chk(v == 32'h600C, "R8 final address", v, 32'h600C);
    rd(3'd3, v); chk(v == 0, "R8 next pointer loaded", v, 0);
    chk(irq == exp_irq, tag, irq, exp_irq);
    rd(3'd2, v);
    chk(v == ((c3 & 32'h0003_1E00) | 32'h4000 | {30'd0, exp_irq, 1'b1}), "R8 control word fields",
        v, (c3 & 32'h0003_1E00) | 32'h4000 | {30'd0, exp_irq, 1'b1});
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 8; s++) begin
      rd(s[2:0], v);
      chk(v == 0, "R1 reset register value", v, 0);
    end
    chk(!irq && !xfer_req && !fetch_req, "R1 reset outputs idle", {irq, xfer_req, fetch_req}, 0);

    // R1 register access and unused bits
    wr(3'd0, 32'hA5A5_0004); rd(3'd0, v); chk(v == 32'hA5A5_0004, "R1 address register", v, 32'hA5A5_0004);
    wr(3'd3, 32'h1234_5678); rd(3'd3, v); chk(v == 32'h1234_5678, "R1 next register", v, 32'h1234_5678);
    wr(3'd2, 32'hFFFF_FEFF); rd(3'd2, v); chk(v == 32'h0003_5E00, "R1 command unused bits zero", v, 32'h0003_5E00);
    rd(3'd5, v); chk(v == 0, "R1 unmapped select", v, 0);
    wr(3'd2, 32'd0);

    // R2 R5 R10 sweep over counts, directions and policies
    for (int p = 0; p < 4; p++)
      for (int n = 1; n <= 5; n++) begin
        run_normal(n, 4'b0110, p[1:0]);
        run_normal(n, 4'b0111, p[1:0]);
      end

    // R11 clear register
    run_normal(2, 4'b0111, 2'b01);
    chk(irq == 1'b1, "R11 irq pending", irq, 1);
    wr(3'd4, 32'h0); rd(3'd2, v);
    chk(!irq && v[1] == 1'b0, "R11 irq cleared by select 4", {irq, v[1]}, 0);

    // R3 done cleared by a non-zero count write
    rd(3'd2, v); chk(v[0] == 1'b1, "R3 done before count write", v[0], 1);
    wr(3'd1, 32'd5); rd(3'd2, v); chk(v[0] == 1'b0, "R3 non-zero count clears done", v[0], 0);

    // R3 done cleared by start-0 write, R4 zero count
    run_normal(1, 4'b0110, 2'b00);
    wr(3'd2, 32'h0C00); rd(3'd2, v); chk(v[0] == 1'b0, "R3 start-0 write clears done", v[0], 0);
    wr(3'd1, 32'd0);
    req_seen = 0;
    wr(3'd2, 32'h0C00 | 32'h100);
    wait_done("R4 zero count sets done");
    chk(req_seen == 0, "R4 no request with zero count", req_seen, 0);

    // R5 no request without device demand
    dev_req = 1'b0; req_seen = 0; beats = 0; exp_dir = 1'b0;
    wr(3'd0, 32'h3000); wr(3'd1, 32'd4); wr(3'd2, 32'h0C00 | 32'h100);
    repeat (20) @(negedge clk);
    chk(req_seen == 0, "R5 request gated by dev_req", req_seen, 0);
    rd(3'd1, v); chk(v == 4, "R5 count held without demand", v, 4);
    dev_req = 1'b1;
    wait_done("R5 demand releases transfer");
    chk(beats == 4, "R5 beats after demand", beats, 4);

    // R6 suspend at tenure end, then resume
    beats = 0; bus_en = 1'b1; exp_dir = 1'b1;
    wr(3'd0, 32'h2000); wr(3'd1, 32'd8); wr(3'd2, 32'h0E00 | 32'h100);
    for (int k = 0; k < 100 && beats < 3; k++) @(negedge clk);
    bus_en = 1'b0;
    wr(3'd2, 32'h0E00);
    @(negedge clk); #2;
    chk(xfer_req == 1'b1, "R6 request held inside tenure", xfer_req, 1);
    tenure_end = 1'b1;
    @(negedge clk);
    tenure_end = 1'b0;
    bus_en = 1'b1;
    repeat (5) @(negedge clk);
    #2;
    chk(xfer_req == 1'b0, "R6 request dropped after tenure end", xfer_req, 0);
    rd(3'd1, v); chk(v == 5, "R6 count held while suspended", v, 5);
    rd(3'd0, v); chk(v == 32'h200C, "R6 address held while suspended", v, 32'h200C);
    wr(3'd2, 32'h0E00 | 32'h100);
    wait_done("R6 resumed run completes");
    chk(beats == 8, "R6 total beats after resume", beats, 8);
    rd(3'd0, v); chk(v == 32'h2020, "R6 final address after resume", v, 32'h2020);

    // R7 R8 R9 R10 chaining with per-descriptor policy
    run_chain(32'h0002_0E00, 32'h0000_0E00, 32'h0002_0E00, 1'b1, "R10 policy 10 on final descriptor");
    run_chain(32'h0002_0E00, 32'h0000_0E00, 32'h0000_0E00, 1'b0, "R10 policy 10 on non-final descriptor");
    run_chain(32'h0001_0C00, 32'h0000_0C00, 32'h0000_0C00, 1'b1, "R10 policy 01 on first descriptor");
    run_chain(32'h0003_0C00, 32'h0003_0C00, 32'h0003_0C00, 1'b0, "R10 policy 11 silent");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule